// File: doc/BRIEF.md
# Motor Drive Protection Supervisor

This block is the single gate that decides whether the power bridge of a three-phase motor drive may switch. It gathers every protective condition into one registered drive-enable output and a registered brake-enable output. The conditions are a rotor-constraint timeout, loss of the speed command clock, a supply undervoltage window and the power-on state. The run and brake requests are also combined in. The protective conditions are reported on a three-bit fault vector.

A rotor-constraint fault sets when the speed-lock flag stays low for a programmable number of cycles while the motor is commanded to run. The fault stays set until the controller holds a stop or brake request for a programmable clear time, or until reset. Command-clock loss sets when no rising edge of the command clock arrives for a programmable number of cycles. It clears as soon as edges return. The supply flag follows a pair of comparator levels with hysteresis, and it is held set after reset until the release level is first seen. All durations are counted in system clock cycles.

Top module: `drive_guard`

## Requirements
- R1: While reset is low and after it is released, drive_en_o and brake_en_o are 0 and fault_o is 3'b100 (bit 2 = supply fault, bit 1 = command clock lost, bit 0 = rotor constrained) until uv_ok_i has been seen high.
- R2: drive_en_o is registered: it is 1 one cycle after a cycle in which run_i=1, brake_i=0 and fault_o=3'b000, and 0 one cycle after any other cycle.
- R3: fault_o bit 2 sets on the edge after uv_trip_i=1. It clears on the edge after uv_trip_i=0 with uv_ok_i=1. When both inputs are 0 it holds its value. Trip has priority.
- R4: With run_i=1 and brake_i=0, lock_i held at 0 for exactly STALL_TICKS consecutive cycles sets fault_o bit 0. After STALL_TICKS-1 such cycles the bit is still 0.
- R5: The constraint timer restarts from zero on any cycle with lock_i=1. Cycles with run_i=0 or brake_i=1 neither advance nor restart it.
- R6: Once set, fault_o bit 0 stays set while run_i=1 and brake_i=0, whatever lock_i and the command clock do.
- R7: fault_o bit 0 clears after CLEAR_TICKS consecutive cycles with run_i=0 or brake_i=1. A shorter hold leaves it set.
- R8: With run_i=1, if no rising edge of cmd_clk_i reaches the block for LOSS_TICKS cycles, fault_o bit 1 sets. A returning edge clears it after the two-stage input synchronizer, and so does run_i=0.
- R9: brake_en_o is 1 one cycle after a cycle with brake_i=1, run_i=1 and fault_o bit 2 = 0. It does not depend on fault bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, power-on state |
| run_i | input | 1 | 1 = start state requested, 0 = stop |
| brake_i | input | 1 | 1 = short-brake requested |
| lock_i | input | 1 | 1 = motor speed inside the lock window |
| cmd_clk_i | input | 1 | Speed command clock, asynchronous |
| uv_trip_i | input | 1 | 1 = supply below the trip level |
| uv_ok_i | input | 1 | 1 = supply above the release level |
| drive_en_o | output | 1 | Bridge PWM switching allowed |
| brake_en_o | output | 1 | Short-brake switching allowed |
| fault_o | output | 3 | {supply, clock lost, constrained} |

## Verification
Several patterns of the lock flag are applied. A lock-low run of exactly the timeout pins the expiry edge. A lock-low run broken by one locked cycle shows that the timer restarts, and one broken by a brake period shows that it freezes instead. Stop and brake holds shorter and longer than the clear time show that only the long one releases the latch. Stopping the command clock with lock kept high isolates the self-clearing clock-loss path, and stopping it with lock low shows that the constraint latch outlives the clock's return. The supply comparators are pulsed separately and together to expose the hysteresis hold and the priority of the trip level.

// File: rtl/drive_guard_pkg.sv
package drive_guard_pkg;
  typedef struct packed {
    logic supply;    // bit 2
    logic clk_lost;  // bit 1
    logic stall;     // bit 0
  } fault_t;
endpackage

// File: rtl/dg_supply_gate.sv
module dg_supply_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_trip_i,
  input  logic uv_ok_i,
  output logic supply_ok_o
);
  logic ok_q, ok_d;

  always_comb begin
    ok_d = ok_q;
    if (uv_trip_i)    ok_d = 1'b0;
    else if (uv_ok_i) ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign supply_ok_o = ok_q;
endmodule

// File: rtl/dg_cmd_watch.sv
module dg_cmd_watch #(
  parameter int unsigned LOSS_TICKS  = 1_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic cmd_clk_i,
  output logic lost_o
);
  localparam int unsigned CW = $clog2(LOSS_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(LOSS_TICKS - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   edge_seen;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   lost_q, lost_d;

  assign sync_d    = {sync_q[SYNC_STAGES-2:0], cmd_clk_i};
  assign edge_seen = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (!run_i || edge_seen) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (!lost_q) begin
      if (cnt_q == LAST) lost_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign lost_o = lost_q;
endmodule

// File: rtl/dg_stall_guard.sv
module dg_stall_guard #(
  parameter int unsigned STALL_TICKS = 50_000_000,
  parameter int unsigned CLEAR_TICKS = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic lock_i,
  output logic stall_o
);
  localparam int unsigned SW = $clog2(STALL_TICKS + 1);
  localparam int unsigned KW = $clog2(CLEAR_TICKS + 1);
  localparam logic [SW-1:0] STALL_LAST = SW'(STALL_TICKS - 1);
  localparam logic [KW-1:0] CLEAR_LAST = KW'(CLEAR_TICKS - 1);

  logic [SW-1:0] tmr_q, tmr_d;
  logic [KW-1:0] hold_q, hold_d;
  logic          stall_q, stall_d;

  always_comb begin
    tmr_d   = tmr_q;
    hold_d  = hold_q;
    stall_d = stall_q;
    // constraint timer: restart on lock, advance only in active state
    if (lock_i) begin
      tmr_d = '0;
    end else if (active_i && !stall_q) begin
      if (tmr_q == STALL_LAST) stall_d = 1'b1;
      else                     tmr_d   = tmr_q + 1'b1;
    end
    // clear counter: consecutive stop/brake cycles
    if (active_i) begin
      hold_d = '0;
    end else if (hold_q == CLEAR_LAST) begin
      stall_d = 1'b0;
      tmr_d   = '0;
    end else begin
      hold_d = hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      hold_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      tmr_q   <= tmr_d;
      hold_q  <= hold_d;
      stall_q <= stall_d;
    end
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/drive_guard.sv
module drive_guard #(
  parameter int unsigned STALL_TICKS = 50_000_000,
  parameter int unsigned CLEAR_TICKS = 100_000,
  parameter int unsigned LOSS_TICKS  = 1_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       brake_i,
  input  logic       lock_i,
  input  logic       cmd_clk_i,
  input  logic       uv_trip_i,
  input  logic       uv_ok_i,
  output logic       drive_en_o,
  output logic       brake_en_o,
  output logic [2:0] fault_o
);
  import drive_guard_pkg::*;

  logic   supply_ok;
  logic   clk_lost;
  logic   stalled;
  logic   active;
  fault_t flt;
  logic   drive_q, drive_d;
  logic   brake_q, brake_d;

  assign active = run_i & ~brake_i;

  dg_supply_gate u_supply (
    .clk(clk), .rst_n(rst_n),
    .uv_trip_i(uv_trip_i), .uv_ok_i(uv_ok_i),
    .supply_ok_o(supply_ok)
  );

  dg_cmd_watch #(.LOSS_TICKS(LOSS_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk(clk), .rst_n(rst_n),
    .run_i(run_i), .cmd_clk_i(cmd_clk_i),
    .lost_o(clk_lost)
  );

  dg_stall_guard #(.STALL_TICKS(STALL_TICKS), .CLEAR_TICKS(CLEAR_TICKS)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .active_i(active), .lock_i(lock_i),
    .stall_o(stalled)
  );

  always_comb begin
    flt.supply   = ~supply_ok;
    flt.clk_lost = clk_lost;
    flt.stall    = stalled;
  end

  always_comb begin
    drive_d = active & (flt == '0);
    brake_d = brake_i & run_i & supply_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      brake_q <= 1'b0;
    end else begin
      drive_q <= drive_d;
      brake_q <= brake_d;
    end
  end

  assign drive_en_o = drive_q;
  assign brake_en_o = brake_q;
  assign fault_o    = flt;
endmodule

// File: rtl/drive_guard_chk.sv
module drive_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_i,
  input logic       brake_i,
  input logic       lock_i,
  input logic       uv_trip_i,
  input logic       uv_ok_i,
  input logic       drive_en_o,
  input logic       brake_en_o,
  input logic [2:0] fault_o
);
  p_stop_blocks_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !drive_en_o);

  p_clean_run_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !brake_i && fault_o == 3'b000) |=> drive_en_o);

  p_supply_blocks_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_o[2]) |-> (!drive_en_o && !brake_en_o));

  p_trip_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uv_trip_i |=> fault_o[2]);

  p_release_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_trip_i && uv_ok_i) |=> !fault_o[2]);

  p_hyst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_trip_i && !uv_ok_i) |=> $stable(fault_o[2]));

  p_lock_prevents_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !fault_o[0]) |=> !fault_o[0]);

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o[0] && run_i && !brake_i) |=> fault_o[0]);

  p_stall_blocks_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_o[0]) |-> !drive_en_o);

  p_loss_blocks_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_o[1]) |-> !drive_en_o);

  p_brake_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_i && run_i && !fault_o[2]) |=> brake_en_o);
endmodule

bind drive_guard drive_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .brake_i(brake_i),
  .lock_i(lock_i), .uv_trip_i(uv_trip_i), .uv_ok_i(uv_ok_i),
  .drive_en_o(drive_en_o), .brake_en_o(brake_en_o), .fault_o(fault_o)
);

// File: tb/sim_drive_guard.sv
`timescale 1ns/1ps
module sim_drive_guard;
  localparam int unsigned STALL = 300;
  localparam int unsigned CLEAR = 100;
  localparam int unsigned LOSS  = 40;

  logic       clk;
  logic       rst_n;
  logic       run_i, brake_i, lock_i, cmd_clk_i, uv_trip_i, uv_ok_i;
  logic       drive_en_o, brake_en_o;
  logic [2:0] fault_o;
  logic       gen_on;
  int         checks;
  int         errors;

  drive_guard #(.STALL_TICKS(STALL), .CLEAR_TICKS(CLEAR), .LOSS_TICKS(LOSS)) u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .brake_i(brake_i),
    .lock_i(lock_i), .cmd_clk_i(cmd_clk_i), .uv_trip_i(uv_trip_i),
    .uv_ok_i(uv_ok_i), .drive_en_o(drive_en_o), .brake_en_o(brake_en_o),
    .fault_o(fault_o)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // command clock: rising edge every 16 system cycles while enabled
  initial begin
    int div;
    div = 0;
    cmd_clk_i = 1'b0;
    forever begin
      @(negedge clk);
      if (gen_on) begin
        div++;
        if (div == 8) begin
          cmd_clk_i = ~cmd_clk_i;
          div = 0;
        end
      end else begin
        cmd_clk_i = 1'b0;
        div = 0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; run_i = 1'b1; brake_i = 1'b0; lock_i = 1'b1;
    uv_trip_i = 1'b0; uv_ok_i = 1'b0; gen_on = 1'b1;
    step(3);
    check("R1 fault in reset", 32'(fault_o), 32'h4);
    check("R1 drive in reset", 32'(drive_en_o), 32'h0);
    rst_n = 1'b1;
    step(5);
    check("R1 fault before release", 32'(fault_o), 32'h4);
    check("R1 drive before release", 32'(drive_en_o), 32'h0);
    check("R1 brake before release", 32'(brake_en_o), 32'h0);
  endtask

  task automatic t_supply_and_run;
    uv_ok_i = 1'b1;
    step(1);
    uv_ok_i = 1'b0;
    check("R3 release clears", 32'(fault_o), 32'h0);
    step(1);
    check("R2 drive one cycle later", 32'(drive_en_o), 32'h1);
    step(3);
    check("R3 hold after release", 32'(fault_o[2]), 32'h0);
    brake_i = 1'b1;
    step(1);
    check("R2 brake drops drive", 32'(drive_en_o), 32'h0);
    check("R9 brake enabled", 32'(brake_en_o), 32'h1);
    brake_i = 1'b0; run_i = 1'b0;
    step(1);
    check("R2 stop drive", 32'(drive_en_o), 32'h0);
    check("R9 stop brake", 32'(brake_en_o), 32'h0);
    run_i = 1'b1;
    step(2);
    check("R2 drive resumes", 32'(drive_en_o), 32'h1);
  endtask

  task automatic t_uv_trip;
    uv_trip_i = 1'b1;
    step(1);
    check("R3 trip sets", 32'(fault_o[2]), 32'h1);
    step(1);
    check("R3 trip blocks drive", 32'(drive_en_o), 32'h0);
    uv_ok_i = 1'b1;
    step(2);
    check("R3 trip has priority", 32'(fault_o[2]), 32'h1);
    uv_trip_i = 1'b0; uv_ok_i = 1'b0;
    step(3);
    check("R3 hysteresis hold", 32'(fault_o[2]), 32'h1);
    uv_ok_i = 1'b1;
    step(1);
    uv_ok_i = 1'b0;
    check("R3 release", 32'(fault_o[2]), 32'h0);
    step(1);
    check("R2 drive after release", 32'(drive_en_o), 32'h1);
  endtask

  task automatic t_stall_latch;
    lock_i = 1'b0;
    step(STALL - 1);
    check("R4 not yet expired", 32'(fault_o[0]), 32'h0);
    step(1);
    check("R4 expiry", 32'(fault_o[0]), 32'h1);
    step(1);
    check("R4 drive off", 32'(drive_en_o), 32'h0);
    lock_i = 1'b1;
    step(20);
    check("R6 latch survives lock", 32'(fault_o), 32'h1);
    brake_i = 1'b1;
    step(50);
    check("R9 brake under stall", 32'(brake_en_o), 32'h1);
    check("R7 short brake keeps latch", 32'(fault_o[0]), 32'h1);
    brake_i = 1'b0;
    step(5);
    check("R6 latch after short brake", 32'(fault_o[0]), 32'h1);
    brake_i = 1'b1;
    step(CLEAR + 5);
    check("R7 long brake clears", 32'(fault_o[0]), 32'h0);
    brake_i = 1'b0;
    step(2);
    check("R7 drive after clear", 32'(drive_en_o), 32'h1);
  endtask

  task automatic t_timer_reset_freeze;
    lock_i = 1'b0;
    step(200);
    lock_i = 1'b1;
    step(1);
    lock_i = 1'b0;
    step(200);
    check("R5 lock restarts timer", 32'(fault_o[0]), 32'h0);
    lock_i = 1'b1;
    step(1);
    lock_i = 1'b0;
    step(200);
    brake_i = 1'b1;
    step(50);
    brake_i = 1'b0;
    step(STALL - 200 - 5);
    check("R5 frozen timer not yet expired", 32'(fault_o[0]), 32'h0);
    step(10);
    check("R5 frozen timer resumes", 32'(fault_o[0]), 32'h1);
    lock_i = 1'b1; run_i = 1'b0;
    step(CLEAR + 10);
    check("R7 stop clears", 32'(fault_o[0]), 32'h0);
    run_i = 1'b1;
    step(2);
    check("R2 drive after stop clear", 32'(drive_en_o), 32'h1);
  endtask

  task automatic t_clock_loss;
    gen_on = 1'b0;
    step(20);
    check("R8 short gap no loss", 32'(fault_o[1]), 32'h0);
    step(60);
    check("R8 loss flagged", 32'(fault_o), 32'h2);
    check("R8 loss blocks drive", 32'(drive_en_o), 32'h0);
    gen_on = 1'b1;
    step(25);
    check("R8 loss self clears", 32'(fault_o[1]), 32'h0);
    check("R8 drive resumes", 32'(drive_en_o), 32'h1);
    gen_on = 1'b0;
    step(80);
    check("R8 loss again", 32'(fault_o[1]), 32'h1);
    run_i = 1'b0;
    step(2);
    check("R8 stop clears loss", 32'(fault_o[1]), 32'h0);
    run_i = 1'b1; gen_on = 1'b1;
    step(25);
  endtask

  task automatic t_loss_then_stall;
    gen_on = 1'b0; lock_i = 1'b0;
    step(STALL + 10);
    check("R8 both faults", 32'(fault_o), 32'h3);
    gen_on = 1'b1;
    step(25);
    check("R6 stall outlives clock return", 32'(fault_o), 32'h1);
    check("R6 drive stays off", 32'(drive_en_o), 32'h0);
    lock_i = 1'b1; brake_i = 1'b1;
    step(CLEAR + 5);
    brake_i = 1'b0;
    step(2);
    check("R7 final clear", 32'(fault_o), 32'h0);
    check("R2 final drive", 32'(drive_en_o), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    gen_on = 1'b0;
    t_reset();
    t_supply_and_run();
    t_uv_trip();
    t_stall_latch();
    t_timer_reset_freeze();
    t_clock_loss();
    t_loss_then_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule